// File: doc/BRIEF.md
# Address Window Response Multiplexer

This block sits in the read and write response path of a bus slave. Behind the slave are up to four memory windows and one register group. Each window covers an inclusive range of word addresses, and each window may be read-write, read-only or write-only. The block is purely combinational.

For each bus direction, the word address is compared against every window. The first window in index order that contains the address is selected for that direction. The block then merges the responses of the windows and the register group into one data, done and error result. When an access goes in a direction the matched window does not support, the access does not complete: it reports an error. When no window contains the address, the register group answers.

Read and write are decoded from separate address inputs. A bus that shares one address for both directions simply drives the same value on both inputs.

Top module: `area_mux`

## Requirements
- R1: The word address is the byte address with its lowest BYTE_BITS bits dropped. Window i contains a word address w when WIN_LO[i] <= w <= WIN_HI[i], with both bounds included. Byte-offset bits never affect the match.
- R2: Windows are tried in ascending index order and the lowest-index containing window wins. At most one read select and at most one write select is high at any time.
- R3: The read select of window i is 1 exactly when window i is the matched window for the read address and window i is readable. The write select behaves the same way for the write address and write permission. Selects depend on the address only, not on the strobes.
- R4: A read that matches a readable window returns that window's data, done and error. A write that matches a writable window returns that window's done and error.
- R5: When no window contains the address, the outputs of that direction take the register group's data, done and error.
- R6: A read that matches a window without read permission returns data 0 and done 0, and its read error equals rd_stb.
- R7: A write that matches a window without write permission returns done 0, and its write error equals wr_stb.
- R8: The read path uses only rd_addr and the write path uses only wr_addr, so the two directions can match different windows at the same time.
- R9: With BUSERR_EN = 0, rd_err and wr_err are always 0. All other outputs are unchanged.
- R10: WIN_ACC[i] bit 0 grants read permission and bit 1 grants write permission. By default, window 0 is read-write, window 1 is read-only and window 2 is write-only, over word ranges 0x100-0x1FF, 0x200-0x23F and 0x300-0x30F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_addr | input | ADDR_W | Byte address of the read access |
| wr_addr | input | ADDR_W | Byte address of the write access |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| win_rd_data | input | NWIN*DATA_W | Read data of each window, window i at bits i*DATA_W upward |
| win_rd_done | input | NWIN | Read done of each window |
| win_rd_err | input | NWIN | Read error of each window |
| win_wr_done | input | NWIN | Write done of each window |
| win_wr_err | input | NWIN | Write error of each window |
| reg_rd_data | input | DATA_W | Register group read data |
| reg_rd_done | input | 1 | Register group read done |
| reg_rd_err | input | 1 | Register group read error |
| reg_wr_done | input | 1 | Register group write done |
| reg_wr_err | input | 1 | Register group write error |
| win_rd_sel | output | NWIN | Per-window read select |
| win_wr_sel | output | NWIN | Per-window write select |
| rd_data | output | DATA_W | Merged read data |
| rd_done | output | 1 | Merged read done |
| rd_err | output | 1 | Merged read error |
| wr_done | output | 1 | Merged write done |
| wr_err | output | 1 | Merged write error |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle as the address that triggers it. A bound that is off by one only shows when the address is exactly one word outside a window edge. For that reason, the stimulus is weighted toward the words just inside and just outside every window bound. A permission fault shows as done asserted, or error missing, on an access in the wrong direction. A swapped address path shows only when the read and write addresses fall in different windows, so those cases are driven on purpose.

// File: rtl/amux_pkg.sv
package amux_pkg;

    // Permission bits inside a per-window access code.
    localparam int unsigned ACC_RD_BIT = 0;
    localparam int unsigned ACC_WR_BIT = 1;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_WO   = 2'b10,
        ACC_RW   = 2'b11
    } win_acc_e;

    // Completion flags of one response source.
    typedef struct packed {
        logic done;
        logic err;
    } flag_t;

    // Inclusive range test on word addresses.
    function automatic logic word_in_range(input logic [31:0] wa,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
        return (wa >= lo) && (wa <= hi);
    endfunction

endpackage

// File: rtl/amux_decode.sv
module amux_decode #(
    parameter int          NWIN   = 3,
    parameter int          WA_W   = 14,
    parameter int unsigned WIN_LO [4] = '{32'h100, 32'h200, 32'h300, 32'h380},
    parameter int unsigned WIN_HI [4] = '{32'h1FF, 32'h23F, 32'h30F, 32'h3FF}
) (
    input  logic [WA_W-1:0] word_addr,
    output logic [NWIN-1:0] hit
);
    import amux_pkg::*;

    logic [NWIN-1:0] raw_hit;
    logic            taken;

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        assign raw_hit[g] = word_in_range(32'(word_addr), WIN_LO[g], WIN_HI[g]);
    end

    // Priority chain: the first containing window takes the access.
    always_comb begin
        hit   = '0;
        taken = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            if (!taken && raw_hit[i]) begin
                hit[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/amux_flag_route.sv
module amux_flag_route #(
    parameter int          NWIN      = 3,
    parameter int unsigned DIR_BIT   = 0,
    parameter logic [1:0]  WIN_ACC [4] = '{2'b11, 2'b01, 2'b10, 2'b11},
    parameter bit          BUSERR_EN = 1'b1
) (
    input  logic [NWIN-1:0] hit,
    input  logic            strobe,
    input  logic [NWIN-1:0] win_done,
    input  logic [NWIN-1:0] win_err,
    input  logic            reg_done,
    input  logic            reg_err,
    output logic [NWIN-1:0] sel,
    output logic [NWIN-1:0] deny,
    output logic            done,
    output logic            err
);
    import amux_pkg::*;

    logic [NWIN-1:0] permit;
    flag_t           merged;

    for (genvar g = 0; g < NWIN; g++) begin : g_perm
        assign permit[g] = WIN_ACC[g][DIR_BIT];
        assign sel[g]    = hit[g] & permit[g];
        assign deny[g]   = hit[g] & ~permit[g];
    end

    always_comb begin
        merged = '{done: reg_done, err: reg_err};
        for (int i = 0; i < NWIN; i++) begin
            if (hit[i]) begin
                if (permit[i]) merged = '{done: win_done[i], err: win_err[i]};
                else           merged = '{done: 1'b0,        err: strobe};
            end
        end
    end

    assign done = merged.done;

    if (BUSERR_EN) begin : g_err
        assign err = merged.err;
    end else begin : g_no_err
        assign err = 1'b0;
    end

endmodule

// File: rtl/amux_data_mux.sv
module amux_data_mux #(
    parameter int NWIN   = 3,
    parameter int DATA_W = 32
) (
    input  logic [NWIN-1:0]        sel,
    input  logic [NWIN-1:0]        deny,
    input  logic [NWIN*DATA_W-1:0] win_data,
    input  logic [DATA_W-1:0]      reg_data,
    output logic [DATA_W-1:0]      data
);
    always_comb begin
        data = reg_data;
        for (int i = 0; i < NWIN; i++) begin
            if (sel[i])  data = win_data[i*DATA_W +: DATA_W];
            if (deny[i]) data = '0;
        end
    end

endmodule

// File: rtl/area_mux.sv
module area_mux #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          BYTE_BITS = 2,
    parameter int          NWIN      = 3,
    parameter int unsigned WIN_LO [4] = '{32'h100, 32'h200, 32'h300, 32'h380},
    parameter int unsigned WIN_HI [4] = '{32'h1FF, 32'h23F, 32'h30F, 32'h3FF},
    parameter logic [1:0]  WIN_ACC [4] = '{2'b11, 2'b01, 2'b10, 2'b11},
    parameter bit          BUSERR_EN = 1'b1
) (
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic                   rd_stb,
    input  logic                   wr_stb,
    input  logic [NWIN*DATA_W-1:0] win_rd_data,
    input  logic [NWIN-1:0]        win_rd_done,
    input  logic [NWIN-1:0]        win_rd_err,
    input  logic [NWIN-1:0]        win_wr_done,
    input  logic [NWIN-1:0]        win_wr_err,
    input  logic [DATA_W-1:0]      reg_rd_data,
    input  logic                   reg_rd_done,
    input  logic                   reg_rd_err,
    input  logic                   reg_wr_done,
    input  logic                   reg_wr_err,
    output logic [NWIN-1:0]        win_rd_sel,
    output logic [NWIN-1:0]        win_wr_sel,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   rd_done,
    output logic                   rd_err,
    output logic                   wr_done,
    output logic                   wr_err
);
    import amux_pkg::*;

    localparam int WA_W = ADDR_W - BYTE_BITS;

    logic [WA_W-1:0] rd_word;
    logic [WA_W-1:0] wr_word;
    logic            byte_ofs_unused;
    logic [NWIN-1:0] rd_hit;
    logic [NWIN-1:0] wr_hit;
    logic [NWIN-1:0] rd_deny;
    logic [NWIN-1:0] wr_deny_unused;

    assign rd_word         = rd_addr[ADDR_W-1:BYTE_BITS];
    assign wr_word         = wr_addr[ADDR_W-1:BYTE_BITS];
    assign byte_ofs_unused = ^{rd_addr[BYTE_BITS-1:0], wr_addr[BYTE_BITS-1:0]};

    amux_decode #(.NWIN(NWIN), .WA_W(WA_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI))
    u_rd_dec (.word_addr(rd_word), .hit(rd_hit));

    amux_decode #(.NWIN(NWIN), .WA_W(WA_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI))
    u_wr_dec (.word_addr(wr_word), .hit(wr_hit));

    amux_flag_route #(.NWIN(NWIN), .DIR_BIT(ACC_RD_BIT), .WIN_ACC(WIN_ACC),
                      .BUSERR_EN(BUSERR_EN))
    u_rd_flags (
        .hit(rd_hit), .strobe(rd_stb),
        .win_done(win_rd_done), .win_err(win_rd_err),
        .reg_done(reg_rd_done), .reg_err(reg_rd_err),
        .sel(win_rd_sel), .deny(rd_deny),
        .done(rd_done), .err(rd_err)
    );

    amux_flag_route #(.NWIN(NWIN), .DIR_BIT(ACC_WR_BIT), .WIN_ACC(WIN_ACC),
                      .BUSERR_EN(BUSERR_EN))
    u_wr_flags (
        .hit(wr_hit), .strobe(wr_stb),
        .win_done(win_wr_done), .win_err(win_wr_err),
        .reg_done(reg_wr_done), .reg_err(reg_wr_err),
        .sel(win_wr_sel), .deny(wr_deny_unused),
        .done(wr_done), .err(wr_err)
    );

    amux_data_mux #(.NWIN(NWIN), .DATA_W(DATA_W))
    u_rd_data (
        .sel(win_rd_sel), .deny(rd_deny),
        .win_data(win_rd_data), .reg_data(reg_rd_data),
        .data(rd_data)
    );

endmodule

// File: rtl/amux_chk.sv
module amux_chk #(
    parameter int NWIN      = 3,
    parameter int DATA_W    = 32,
    parameter bit BUSERR_EN = 1'b1
) (
    input logic                   rd_stb,
    input logic                   wr_stb,
    input logic [NWIN*DATA_W-1:0] win_rd_data,
    input logic [NWIN-1:0]        win_rd_done,
    input logic [NWIN-1:0]        win_rd_err,
    input logic [NWIN-1:0]        win_wr_done,
    input logic [NWIN-1:0]        win_wr_err,
    input logic [DATA_W-1:0]      reg_rd_data,
    input logic                   reg_rd_done,
    input logic                   reg_rd_err,
    input logic                   reg_wr_done,
    input logic                   reg_wr_err,
    input logic [NWIN-1:0]        win_rd_sel,
    input logic [NWIN-1:0]        win_wr_sel,
    input logic [DATA_W-1:0]      rd_data,
    input logic                   rd_done,
    input logic                   rd_err,
    input logic                   wr_done,
    input logic                   wr_err
);
    always_comb begin
        p_rd_sel_onehot_r2: assert ($onehot0(win_rd_sel))
            else $error("read selects not one-hot");
        p_wr_sel_onehot_r2: assert ($onehot0(win_wr_sel))
            else $error("write selects not one-hot");

        for (int i = 0; i < NWIN; i++) begin
            if (win_rd_sel[i]) begin
                p_rd_route_r4: assert (rd_data == win_rd_data[i*DATA_W +: DATA_W]
                                       && rd_done == win_rd_done[i]
                                       && rd_err == (BUSERR_EN && win_rd_err[i]))
                    else $error("read response not from selected window");
            end
            if (win_wr_sel[i]) begin
                p_wr_route_r4: assert (wr_done == win_wr_done[i]
                                       && wr_err == (BUSERR_EN && win_wr_err[i]))
                    else $error("write response not from selected window");
            end
        end

        // No select: either the register group answers or a denied access.
        if (win_rd_sel == '0) begin
            p_rd_fallback_r5: assert ((rd_data == reg_rd_data && rd_done == reg_rd_done
                                       && rd_err == (BUSERR_EN && reg_rd_err))
                                      || (rd_data == '0 && !rd_done
                                          && rd_err == (BUSERR_EN && rd_stb)))
                else $error("unselected read has unexpected response");
        end
        if (win_wr_sel == '0) begin
            p_wr_fallback_r5: assert ((wr_done == reg_wr_done
                                       && wr_err == (BUSERR_EN && reg_wr_err))
                                      || (!wr_done && wr_err == (BUSERR_EN && wr_stb)))
                else $error("unselected write has unexpected response");
        end

        if (!BUSERR_EN) begin
            p_no_err_r9: assert (!rd_err && !wr_err)
                else $error("error reported with error reporting disabled");
        end
    end

endmodule

bind area_mux amux_chk #(.NWIN(NWIN), .DATA_W(DATA_W), .BUSERR_EN(BUSERR_EN)) u_amux_chk (
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .win_rd_data(win_rd_data), .win_rd_done(win_rd_done), .win_rd_err(win_rd_err),
    .win_wr_done(win_wr_done), .win_wr_err(win_wr_err),
    .reg_rd_data(reg_rd_data), .reg_rd_done(reg_rd_done), .reg_rd_err(reg_rd_err),
    .reg_wr_done(reg_wr_done), .reg_wr_err(reg_wr_err),
    .win_rd_sel(win_rd_sel), .win_wr_sel(win_wr_sel),
    .rd_data(rd_data), .rd_done(rd_done), .rd_err(rd_err),
    .wr_done(wr_done), .wr_err(wr_err)
);

// File: tb/test_area_mux.sv
module test_area_mux;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NWIN   = 3;

    // Window table from R10.
    localparam int unsigned LO [3] = '{32'h100, 32'h200, 32'h300};
    localparam int unsigned HI [3] = '{32'h1FF, 32'h23F, 32'h30F};
    localparam bit          RDOK [3] = '{1'b1, 1'b1, 1'b0};
    localparam bit          WROK [3] = '{1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [ADDR_W-1:0]      rd_addr, wr_addr;
    logic                   rd_stb, wr_stb;
    logic [NWIN*DATA_W-1:0] win_rd_data;
    logic [NWIN-1:0]        win_rd_done, win_rd_err, win_wr_done, win_wr_err;
    logic [DATA_W-1:0]      reg_rd_data;
    logic                   reg_rd_done, reg_rd_err, reg_wr_done, reg_wr_err;

    logic [NWIN-1:0]   win_rd_sel, win_wr_sel, n_rd_sel, n_wr_sel;
    logic [DATA_W-1:0] rd_data, n_rd_data;
    logic              rd_done, rd_err, wr_done, wr_err;
    logic              n_rd_done, n_rd_err, n_wr_done, n_wr_err;

    area_mux i_area_mux (
        .rd_addr, .wr_addr, .rd_stb, .wr_stb,
        .win_rd_data, .win_rd_done, .win_rd_err, .win_wr_done, .win_wr_err,
        .reg_rd_data, .reg_rd_done, .reg_rd_err, .reg_wr_done, .reg_wr_err,
        .win_rd_sel, .win_wr_sel, .rd_data, .rd_done, .rd_err, .wr_done, .wr_err
    );

    area_mux #(.BUSERR_EN(1'b0)) i_area_mux_noerr (
        .rd_addr, .wr_addr, .rd_stb, .wr_stb,
        .win_rd_data, .win_rd_done, .win_rd_err, .win_wr_done, .win_wr_err,
        .reg_rd_data, .reg_rd_done, .reg_rd_err, .reg_wr_done, .reg_wr_err,
        .win_rd_sel(n_rd_sel), .win_wr_sel(n_wr_sel), .rd_data(n_rd_data),
        .rd_done(n_rd_done), .rd_err(n_rd_err), .wr_done(n_wr_done), .wr_err(n_wr_err)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string ctx = "reset";

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s (%s) actual=%0h expected=%0h", req, what, ctx, act, exp);
        end
    endtask

    // R1: word address is the byte address shifted down by two.
    function automatic int win_of(logic [ADDR_W-1:0] a);
        int unsigned wa = 32'(a >> 2);
        for (int k = 0; k < NWIN; k++)
            if (wa >= LO[k] && wa <= HI[k]) return k;
        return -1;
    endfunction

    task automatic check_all();
        int ri = win_of(rd_addr);
        int wi = win_of(wr_addr);
        logic [DATA_W-1:0] e_data;
        logic e_done, e_err;
        logic [NWIN-1:0] e_sel;
        string req;
        // read direction
        if (ri < 0) begin
            e_data = reg_rd_data; e_done = reg_rd_done; e_err = reg_rd_err; e_sel = '0; req = "R5";
        end else if (RDOK[ri]) begin
            e_data = win_rd_data[ri*DATA_W +: DATA_W]; e_done = win_rd_done[ri];
            e_err = win_rd_err[ri]; e_sel = NWIN'(1 << ri); req = "R4";
        end else begin
            e_data = '0; e_done = 1'b0; e_err = rd_stb; e_sel = '0; req = "R6";
        end
        chk(req, "rd_data", 64'(rd_data), 64'(e_data));
        chk(req, "rd_done", 64'(rd_done), 64'(e_done));
        chk(req, "rd_err", 64'(rd_err), 64'(e_err));
        chk("R3", "win_rd_sel", 64'(win_rd_sel), 64'(e_sel));
        chk("R2", "rd_sel_count_le1", 64'($countones(win_rd_sel) <= 1), 64'd1);
        chk("R9", "rd_data_noerr", 64'(n_rd_data), 64'(e_data));
        chk("R9", "rd_done_noerr", 64'(n_rd_done), 64'(e_done));
        chk("R9", "rd_err_noerr", 64'(n_rd_err), 64'd0);
        chk("R9", "rd_sel_noerr", 64'(n_rd_sel), 64'(e_sel));
        // write direction
        if (wi < 0) begin
            e_done = reg_wr_done; e_err = reg_wr_err; e_sel = '0; req = "R5";
        end else if (WROK[wi]) begin
            e_done = win_wr_done[wi]; e_err = win_wr_err[wi]; e_sel = NWIN'(1 << wi); req = "R4";
        end else begin
            e_done = 1'b0; e_err = wr_stb; e_sel = '0; req = "R7";
        end
        chk(req, "wr_done", 64'(wr_done), 64'(e_done));
        chk(req, "wr_err", 64'(wr_err), 64'(e_err));
        chk("R3", "win_wr_sel", 64'(win_wr_sel), 64'(e_sel));
        chk("R9", "wr_done_noerr", 64'(n_wr_done), 64'(e_done));
        chk("R9", "wr_err_noerr", 64'(n_wr_err), 64'd0);
    endtask

    task automatic rand_payload();
        win_rd_data = {$urandom, $urandom, $urandom};
        win_rd_done = NWIN'($urandom); win_rd_err = NWIN'($urandom);
        win_wr_done = NWIN'($urandom); win_wr_err = NWIN'($urandom);
        reg_rd_data = $urandom;
        {reg_rd_done, reg_rd_err, reg_wr_done, reg_wr_err, rd_stb, wr_stb} = 6'($urandom);
    endtask

    function automatic logic [ADDR_W-1:0] pick_addr();
        int unsigned k    = $urandom % NWIN;
        int unsigned base = ($urandom % 2) ? HI[k] : LO[k];
        int unsigned wa   = base + ($urandom % 3) - 1;
        if ($urandom % 4 == 0) return ADDR_W'($urandom);
        return {wa[13:0], 2'($urandom)};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic sample();
        #8;
        check_all();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rd_addr = '0; wr_addr = '0; rd_stb = 0; wr_stb = 0;
        win_rd_data = '0; win_rd_done = '0; win_rd_err = '0;
        win_wr_done = '0; win_wr_err = '0;
        reg_rd_data = '0; reg_rd_done = 0; reg_rd_err = 0; reg_wr_done = 0; reg_wr_err = 0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // reset state: address 0 belongs to no window, all zero (R5)
        sample();

        // R1: inclusive bounds, one word outside, byte offset ignored
        ctx = "R1 edges";
        for (int k = 0; k < NWIN; k++) begin
            for (int e = 0; e < 4; e++) begin
                int unsigned wa;
                case (e)
                    0: wa = LO[k] - 1;
                    1: wa = LO[k];
                    2: wa = HI[k];
                    default: wa = HI[k] + 1;
                endcase
                for (int ofs = 0; ofs < 4; ofs += 3) begin
                    step();
                    rand_payload();
                    rd_stb = 1; wr_stb = 1;
                    rd_addr = {wa[13:0], 2'(ofs)};
                    wr_addr = {wa[13:0], 2'(3 - ofs)};
                    sample();
                end
            end
        end

        // R8: read and write land in different windows
        ctx = "R8 split";
        step(); rand_payload(); rd_addr = 16'(32'h120 << 2); wr_addr = 16'(32'h305 << 2); sample();
        step(); rand_payload(); rd_addr = 16'(32'h30F << 2); wr_addr = 16'(32'h200 << 2); sample();
        step(); rand_payload(); rd_addr = 16'(32'h23F << 2); wr_addr = 16'(32'h000 << 2); sample();

        // R6 and R7 with strobes low and high
        ctx = "R6 R7 strobes";
        for (int s = 0; s < 2; s++) begin
            step(); rand_payload();
            rd_stb = s[0]; wr_stb = s[0];
            rd_addr = 16'(32'h300 << 2); wr_addr = 16'(32'h210 << 2);
            sample();
        end

        ctx = "random";
        for (int n = 0; n < 3000; n++) begin
            step();
            rand_payload();
            rd_addr = pick_addr();
            wr_addr = ($urandom % 3 == 0) ? rd_addr : pick_addr();
            sample();
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule